// File: doc/BRIEF.md
# Serial Combination Lock Controller

This controller opens a lock only after a secret of `KEY_BITS` bits (three by default) has been entered one bit at a time. The secret is presented on a parallel input by surrounding logic. The user drives a single key switch and confirms each bit with a one-cycle enter pulse. The bit on the switch is taken in the cycle right after the pulse and compared with the matching secret bit, first bit first.

A wrong bit does not stop or shorten the sequence. From that point the controller follows a shadow path with exactly the same cycle timing as the success path. The user must still confirm every remaining bit, and the failure is shown only after the final bit has been judged. Nothing observable separates a good entry from a bad one until the end.

The result is held until reset. The synchronous active-high reset is also the user's restart button: it returns the controller to the waiting-for-first-bit condition from any point in the sequence.

Top module: `serlock_top`

## Requirements
- R1: After reset, `unlock_o` and `error_o` are both 0. They stay 0 while `enter_i` is low, and the controller waits for the first bit.
- R2: When `enter_i` is high at a rising edge in a waiting condition, `key_i` is sampled at the next rising edge. The key value at any other edge has no effect.
- R3: The n-th confirmed bit (n counting from 0) is compared with `code_i[n]`. Bit 0 of `code_i` is checked first and bit `KEY_BITS-1` last.
- R4: If every confirmed bit equals its code bit, `unlock_o` goes to 1 exactly two rising edges after the edge that sampled the final enter pulse.
- R5: If any confirmed bit differs from its code bit, `error_o` goes to 1 at the same point where `unlock_o` would have gone high. Neither output is 1 before the final bit has been judged.
- R6: Once a bit has mismatched, the values of the later bits do not affect the outcome: the result is always `error_o` = 1.
- R7: `enter_i` is ignored in the cycle in which a bit is being compared. Holding enter high for two cycles counts as a single confirmation.
- R8: Once `unlock_o` or `error_o` is 1, it stays 1 until reset, whatever `enter_i` and `key_i` do.
- R9: `unlock_o` and `error_o` are never 1 in the same cycle.
- R10: Reset asserted at a rising edge, at any point in a sequence, clears both outputs at that edge. The next full entry is judged from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset and user restart |
| enter_i | input | 1 | One-cycle confirmation pulse for the current bit |
| key_i | input | 1 | Key switch value for the bit being entered |
| code_i | input | KEY_BITS | Stored secret, bit 0 entered first |
| unlock_o | output | 1 | High once the whole secret matched |
| error_o | output | 1 | High once the whole entry was judged wrong |

## Verification
The hardest condition to reach from the ports is the shadow error path. From outside, it must be indistinguishable from a good entry until the final judgement. The stimulus forces an early mismatch followed by correct bits, and it checks that both outputs stay low through every intermediate wait. It also varies the wait length between confirmations, stretches enter into the compare cycle, and scrambles the key switch outside the sampling cycle. Together these show that only the sampled bit and the final verdict timing matter.

// File: rtl/serlock_pkg.sv
package serlock_pkg;

    // Phase of the entry sequence; the compare-bit index and the
    // mismatch flag complete the state.
    typedef enum logic [2:0] {
        PH_ARMED = 3'd0,   // waiting for first confirmation
        PH_CHECK = 3'd1,   // one-cycle compare of the current bit
        PH_HOLD  = 3'd2,   // waiting for the next confirmation
        PH_OPEN  = 3'd3,   // entry accepted
        PH_ALARM = 3'd4    // entry rejected
    } phase_e;

    typedef struct packed {
        logic unlock;
        logic alarm;
    } verdict_t;

    function automatic verdict_t decode_phase(phase_e p);
        verdict_t v;
        v.unlock = (p == PH_OPEN);
        v.alarm  = (p == PH_ALARM);
        return v;
    endfunction

    function automatic logic bit_differs(logic entered, logic secret);
        return entered ^ secret;
    endfunction

    function automatic logic waits_for_enter(phase_e p);
        return (p == PH_ARMED) || (p == PH_HOLD);
    endfunction

endpackage

// File: rtl/serlock_sequencer.sv
module serlock_sequencer
    import serlock_pkg::*;
#(
    parameter int KEY_BITS = 3,
    parameter int IDX_W    = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enter_i,
    input  logic             taint_now_i,
    output phase_e           phase_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BITS - 1);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        unique case (phase_q)
            PH_ARMED: begin
                if (enter_i) begin
                    phase_d = PH_CHECK;
                    idx_d   = '0;
                end
            end
            PH_CHECK: begin
                if (idx_q == LAST_IDX) begin
                    phase_d = taint_now_i ? PH_ALARM : PH_OPEN;
                end else begin
                    phase_d = PH_HOLD;
                    idx_d   = idx_q + IDX_W'(1);
                end
            end
            PH_HOLD: begin
                if (enter_i) begin
                    phase_d = PH_CHECK;
                end
            end
            PH_OPEN, PH_ALARM: begin
                phase_d = phase_q;
            end
            default: begin
                phase_d = PH_ARMED;
                idx_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            phase_q <= PH_ARMED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;

endmodule

// File: rtl/serlock_judge.sv
module serlock_judge
    import serlock_pkg::*;
#(
    parameter int KEY_BITS = 3,
    parameter int IDX_W    = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  phase_e              phase_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic                key_i,
    input  logic [KEY_BITS-1:0] code_i,
    output logic                taint_now_o
);
    logic secret_bit;
    logic miss;
    logic taint_q;

    // Select the secret bit for the current position.
    always_comb begin
        secret_bit = 1'b0;
        for (int i = 0; i < KEY_BITS; i++) begin
            if (idx_i == IDX_W'(i)) begin
                secret_bit = code_i[i];
            end
        end
    end

    assign miss = (phase_i == PH_CHECK) && bit_differs(key_i, secret_bit);

    // Sticky mismatch flag: selects the shadow path without changing timing.
    always_ff @(posedge clk_i) begin
        if (rst_i || phase_i == PH_ARMED) begin
            taint_q <= 1'b0;
        end else if (miss) begin
            taint_q <= 1'b1;
        end
    end

    assign taint_now_o = taint_q | miss;

endmodule

// File: rtl/serlock_annunciator.sv
module serlock_annunciator
    import serlock_pkg::*;
(
    input  phase_e phase_i,
    output logic   unlock_o,
    output logic   error_o
);
    verdict_t v;

    always_comb begin
        v        = decode_phase(phase_i);
        unlock_o = v.unlock;
        error_o  = v.alarm;
    end

endmodule

// File: rtl/serlock_top.sv
module serlock_top
    import serlock_pkg::*;
#(
    parameter int KEY_BITS = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                enter_i,
    input  logic                key_i,
    input  logic [KEY_BITS-1:0] code_i,
    output logic                unlock_o,
    output logic                error_o
);
    localparam int IDX_W = (KEY_BITS > 1) ? $clog2(KEY_BITS) : 1;

    phase_e           phase;
    logic [IDX_W-1:0] idx;
    logic             taint_now;

    serlock_sequencer #(.KEY_BITS(KEY_BITS), .IDX_W(IDX_W)) i_sequencer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .enter_i     (enter_i),
        .taint_now_i (taint_now),
        .phase_o     (phase),
        .idx_o       (idx)
    );

    serlock_judge #(.KEY_BITS(KEY_BITS), .IDX_W(IDX_W)) i_judge (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .phase_i     (phase),
        .idx_i       (idx),
        .key_i       (key_i),
        .code_i      (code_i),
        .taint_now_o (taint_now)
    );

    serlock_annunciator i_annunciator (
        .phase_i  (phase),
        .unlock_o (unlock_o),
        .error_o  (error_o)
    );

endmodule

// File: rtl/serlock_checker.sv
module serlock_checker (
    input logic clk_i,
    input logic rst_i,
    input logic enter_i,
    input logic unlock_o,
    input logic error_o
);
    // R9: verdicts are exclusive
    a_r9_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
        !(unlock_o && error_o));

    // R8: accepted verdict is held until reset
    a_r8_unlock_held: assert property (@(posedge clk_i) disable iff (rst_i)
        unlock_o |=> unlock_o);

    // R8: rejected verdict is held until reset
    a_r8_error_held: assert property (@(posedge clk_i) disable iff (rst_i)
        error_o |=> error_o);

    // R4: unlock appears two edges after a confirmation
    a_r4_unlock_timing: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(unlock_o) |-> $past(enter_i, 2));

    // R5: error appears with the same latency as unlock
    a_r5_error_timing: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(error_o) |-> $past(enter_i, 2));

    // R10: reset clears both verdicts
    a_r10_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (!unlock_o && !error_o));

endmodule

bind serlock_top serlock_checker i_serlock_checker (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .enter_i  (enter_i),
    .unlock_o (unlock_o),
    .error_o  (error_o)
);

// File: tb/test_serlock_top.sv
module test_serlock_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enter = 1'b0;
    logic          key = 1'b0;
    logic [NB-1:0] code = '0;
    logic          unlock;
    logic          error;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serlock_top #(.KEY_BITS(NB)) i_serlock_top (
        .clk_i    (clk),
        .rst_i    (rst),
        .enter_i  (enter),
        .key_i    (key),
        .code_i   (code),
        .unlock_o (unlock),
        .error_o  (error)
    );

    function automatic logic exp_open(logic [NB-1:0] keys, logic [NB-1:0] secret);
        return keys == secret;
    endfunction

    task automatic chk(string req, logic exp_u, logic exp_e);
        checks++;
        if (unlock !== exp_u || error !== exp_e) begin
            fails++;
            $display("FAIL %s: unlock/error actual %b%b expected %b%b",
                     req, unlock, error, exp_u, exp_e);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enter = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Starts and ends on a negedge; key held through the sampling cycle.
    task automatic enter_bit(logic k, bit long_enter, int gap);
        enter = 1'b1;
        key   = k;
        @(negedge clk);
        enter = long_enter;      // R7: ignored during compare
        @(negedge clk);
        enter = 1'b0;
        key   = ~k;              // R2: later key values ignored
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            key = 1'($urandom);
        end
    endtask

    task automatic trial(logic [NB-1:0] secret, logic [NB-1:0] keys, bit allow_long);
        logic eo;
        code = secret;
        eo = exp_open(keys, secret);
        for (int i = 0; i < NB; i++) begin
            enter_bit(keys[i], allow_long && 1'($urandom),
                      (i == NB-1) ? 0 : int'($urandom % 3));
            if (i < NB-1) chk("R5 no early verdict", 1'b0, 1'b0);
        end
        // R3 R4 R5 R6: verdict two edges after final confirmation
        chk(eo ? "R4 unlock" : "R5 error", eo, !eo);
        for (int j = 0; j < 3; j++) begin
            enter = 1'b1;
            key = 1'($urandom);
            @(negedge clk);
            enter = 1'b0;
            @(negedge clk);
            chk("R8 verdict held", eo, !eo);
        end
        do_reset();
        chk("R10 reset clears", 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            key = 1'($urandom);
            @(negedge clk);
        end
        chk("R1 idle without enter", 1'b0, 1'b0);

        trial(3'b101, 3'b101, 1'b0);   // R4 all match
        trial(3'b011, 3'b010, 1'b0);   // R3 first bit wrong only
        trial(3'b011, 3'b111, 1'b0);   // R3 last bit wrong only
        trial(3'b000, 3'b001, 1'b0);   // R6 first wrong, rest right
        trial(3'b110, 3'b110, 1'b1);   // R7 stretched enter

        // R10: restart mid-sequence, then a correct entry unlocks
        code = 3'b010;
        enter_bit(1'b1, 1'b0, 1);
        enter_bit(1'b1, 1'b0, 0);
        do_reset();
        chk("R10 mid-sequence reset", 1'b0, 1'b0);
        trial(3'b010, 3'b010, 1'b0);

        for (int t = 0; t < 40; t++) begin
            logic [NB-1:0] s;
            logic [NB-1:0] k;
            s = NB'($urandom);
            k = (($urandom % 2) == 0) ? s : NB'($urandom);
            trial(s, k, 1'b1);         // R2 R3 R6 random entries
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule